// File: doc/BRIEF.md
# Nested-Loop Sequencer for a Bit-Serial Multiplier

This block drives the datapath of a shift-and-add multiplier that works one bit at a time. It holds no operand data. It issues the per-cycle strobes that tell the datapath when to shift each operand register, when to select the adder sum, when to shift the high and low halves of the product, and when to clear the partial step. A pulse on `start` while idle begins one multiply. After N outer iterations of N inner cycles each, the sequencer raises `done` for one cycle and waits for the next request.

The control has two parts. Two binary loop counters, one for the inner loop and one for the outer loop, each have a clear, a count enable and a flag that is set at the last count (N-1). A three-state one-hot machine steps between an idle state, an inner-loop state and a per-iteration step state. Every strobe is a single state bit or the OR of two state bits, so all strobes come straight from flip-flops. The operand width N is a parameter, and one multiply keeps the block busy for N*(N+1) cycles.

Top module: `serial_mult_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the block is idle: every strobe and `done` are 0, and both loop counters are cleared, so the next multiply runs its full length.
- R2: When `start` is 1 in an idle cycle, the next cycle is an inner cycle. In an inner cycle `shift_a`, `shift_hi` and `sel_sum` are 1 and every other output is 0 (output vector 0x07 in the bit order given under R5).
- R3: Each outer iteration contains exactly N consecutive inner cycles.
- R4: Each run of inner cycles is followed by exactly one step cycle. In a step cycle `shift_b`, `shift_hi`, `shift_lo` and `step_clr` are 1, while `shift_a`, `sel_sum` and `done` are 0 (vector 0x3A).
- R5: A multiply consists of exactly N outer iterations, N*(N+1) busy cycles in all, and then the block returns to idle. Output vector bit order, LSB first: shift_a, shift_hi, sel_sum, shift_b, shift_lo, step_clr, done.
- R6: `done` is 1 for exactly one cycle, the first idle cycle after the final step cycle (vector 0x40). It is 0 at all other times.
- R7: `start` has no effect while a multiply is in progress. The running sequence keeps its length and its strobe pattern.
- R8: In an idle cycle, every strobe is 0 whatever `start` is. Exactly one state is active at any time.
- R9: If `start` is held high, multiplies follow one another with a single idle cycle (the `done` cycle) between them.
- R10: A reset during a multiply aborts it and leaves the block idle with `done` at 0. A following `start` then runs a complete, full-length multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiply, sampled while idle |
| shift_a | output | 1 | Shift the multiplicand register (inner cycles) |
| shift_b | output | 1 | Shift the multiplier register (step cycles) |
| shift_hi | output | 1 | Shift the product high half (inner and step cycles) |
| shift_lo | output | 1 | Shift the product low half (step cycles) |
| sel_sum | output | 1 | Select the adder sum into the high half (inner cycles) |
| step_clr | output | 1 | Clear the partial step state (step cycles) |
| done | output | 1 | One-cycle pulse after the last step cycle |

## Verification
The bench compares the strobes against a cycle-by-cycle model, with N=4, across whole runs. A loop counter that stops one count early or late changes where the 0x3A step cycles fall, and it moves `done` away from cycle N*(N+1)+1. Holding `start` high exposes a sequencer that inserts extra idle cycles between runs, or that lets `start` restart a run already in progress. A reset in the middle of a run checks that both counters are cleared: a leftover inner or outer count would make the next multiply finish early.

// File: rtl/serial_seq_pkg.sv
package serial_seq_pkg;
  localparam int ST_IDLE  = 0;
  localparam int ST_INNER = 1;
  localparam int ST_STEP  = 2;
  localparam int ST_COUNT = 3;

  typedef logic [ST_COUNT-1:0] seq_state_t;
endpackage

// File: rtl/loop_counter.sv
module loop_counter #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ce,
  output logic tc
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (ce)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tc = (cnt == LAST);

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ce && !clr && tc) |=> (cnt == '0)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ce && !clr) |=> $stable(cnt)); // R3
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import serial_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       tc_inner,
  input  logic       tc_outer,
  output seq_state_t q,
  output logic       done
);
  seq_state_t nq;

  always_comb begin
    nq = '0;
    if (q[ST_IDLE]) begin
      if (start) nq[ST_INNER] = 1'b1;
      else       nq[ST_IDLE]  = 1'b1;
    end else if (q[ST_INNER]) begin
      if (tc_inner) nq[ST_STEP]  = 1'b1;
      else          nq[ST_INNER] = 1'b1;
    end else if (q[ST_STEP]) begin
      if (tc_outer) nq[ST_IDLE]  = 1'b1;
      else          nq[ST_INNER] = 1'b1;
    end else begin
      nq[ST_IDLE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= seq_state_t'(1 << ST_IDLE);
      done <= 1'b0;
    end else begin
      q    <= nq;
      done <= q[ST_STEP] & tc_outer;
    end
  end

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    $countones(q) == 1); // R8
  AST_START_GO: assert property (@(posedge clk) disable iff (rst)
    (q[ST_IDLE] && start) |=> q[ST_INNER]); // R2
  AST_INNER_STAY: assert property (@(posedge clk) disable iff (rst)
    (q[ST_INNER] && !tc_inner) |=> q[ST_INNER]); // R3
  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    q[ST_STEP] |=> !q[ST_STEP]); // R4
  AST_FINISH: assert property (@(posedge clk) disable iff (rst)
    (q[ST_STEP] && tc_outer) |=> (q[ST_IDLE] && done)); // R5
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import serial_seq_pkg::*;
(
  input  seq_state_t q,
  output logic       ce_inner,
  output logic       clr_inner,
  output logic       ce_outer,
  output logic       clr_outer,
  output logic       shift_a,
  output logic       shift_b,
  output logic       shift_hi,
  output logic       shift_lo,
  output logic       sel_sum,
  output logic       step_clr
);
  always_comb begin
    ce_inner  = q[ST_INNER];
    clr_inner = q[ST_STEP];
    ce_outer  = q[ST_STEP];
    clr_outer = q[ST_IDLE];
    shift_a   = q[ST_INNER];
    sel_sum   = q[ST_INNER];
    shift_b   = q[ST_STEP];
    shift_lo  = q[ST_STEP];
    step_clr  = q[ST_STEP];
    shift_hi  = q[ST_INNER] | q[ST_STEP];
  end
endmodule

// File: rtl/serial_mult_seq.sv
module serial_mult_seq
  import serial_seq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic shift_a,
  output logic shift_b,
  output logic shift_hi,
  output logic shift_lo,
  output logic sel_sum,
  output logic step_clr,
  output logic done
);
  seq_state_t q;
  logic ce_inner, clr_inner, ce_outer, clr_outer;
  logic tc_inner, tc_outer;

  seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tc_inner (tc_inner),
    .tc_outer (tc_outer),
    .q        (q),
    .done     (done)
  );

  loop_counter #(.N(N)) u_inner (
    .clk (clk),
    .rst (rst),
    .clr (clr_inner),
    .ce  (ce_inner),
    .tc  (tc_inner)
  );

  loop_counter #(.N(N)) u_outer (
    .clk (clk),
    .rst (rst),
    .clr (clr_outer),
    .ce  (ce_outer),
    .tc  (tc_outer)
  );

  strobe_decode u_dec (
    .q         (q),
    .ce_inner  (ce_inner),
    .clr_inner (clr_inner),
    .ce_outer  (ce_outer),
    .clr_outer (clr_outer),
    .shift_a   (shift_a),
    .shift_b   (shift_b),
    .shift_hi  (shift_hi),
    .shift_lo  (shift_lo),
    .sel_sum   (sel_sum),
    .step_clr  (step_clr)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !(shift_a || shift_b || shift_hi || shift_lo || sel_sum || step_clr)); // R8
  AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(step_clr)); // R6
endmodule

// File: tb/serial_mult_seq_test.sv
module serial_mult_seq_test;
  localparam int NT    = 4;
  localparam int TOTAL = NT * (NT + 1);
  localparam logic [6:0] V_INNER = 7'h07;
  localparam logic [6:0] V_STEP  = 7'h3A;
  localparam logic [6:0] V_DONE  = 7'h40;
  localparam logic [6:0] V_IDLE  = 7'h00;
  localparam int NPROBE = 11;
  // [12:7] cycle offset after the start edge, [6:0] expected outputs
  localparam logic [12:0] PROBES [NPROBE] = '{
    {6'd1,  V_INNER}, {6'd4,  V_INNER}, {6'd5,  V_STEP},
    {6'd6,  V_INNER}, {6'd10, V_STEP},  {6'd15, V_STEP},
    {6'd16, V_INNER}, {6'd19, V_INNER}, {6'd20, V_STEP},
    {6'd21, V_DONE},  {6'd22, V_IDLE}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic shift_a, shift_b, shift_hi, shift_lo, sel_sum, step_clr, done;
  logic [6:0] obs;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_mult_seq #(.N(NT)) uut (
    .clk(clk), .rst(rst), .start(start),
    .shift_a(shift_a), .shift_b(shift_b), .shift_hi(shift_hi),
    .shift_lo(shift_lo), .sel_sum(sel_sum), .step_clr(step_clr),
    .done(done)
  );

  assign obs = {done, step_clr, shift_lo, shift_b, sel_sum, shift_hi, shift_a};

  always @(posedge clk) cycles <= cycles + 1;

  function automatic logic [6:0] exp_at(int k);
    if (k < 1) return V_IDLE;
    if (k <= TOTAL) return (((k - 1) % (NT + 1)) < NT) ? V_INNER : V_STEP;
    if (k == TOTAL + 1) return V_DONE;
    return V_IDLE;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [6:0] exp, input string tag);
    checks++;
    if (obs !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, obs, exp);
    end
  endtask

  // Launch a run with start held for one edge, then check every cycle.
  task automatic full_run(input string tag);
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int k = 1; k <= TOTAL + 2; k++) begin
      chk(exp_at(k), tag);
      if (k < TOTAL + 2) tick();
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state, start held high during reset must do nothing
    start = 1'b1;
    chk(V_IDLE, "R1 in reset");
    tick();
    chk(V_IDLE, "R1 in reset, start high");
    start = 1'b0;
    rst = 1'b0;
    tick();
    chk(V_IDLE, "R1 after reset");

    // R8: idle stays quiet
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(V_IDLE, "R8 idle quiet");
    end

    // Table walk: R2 R3 R4 R5 R6 probe points
    start = 1'b1;
    tick();
    start = 1'b0;
    begin
      int cur = 1;
      for (int p = 0; p < NPROBE; p++) begin
        while (cur < int'(PROBES[p][12:7])) begin
          tick();
          cur++;
        end
        chk(PROBES[p][6:0], "R5 table probe");
      end
    end
    tick();

    // R3 R4 R5 R6: full cycle-by-cycle model of a run
    full_run("R3/R4 full run");
    tick();

    // R7: start pulses mid-run are ignored
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int k = 1; k <= TOTAL + 2; k++) begin
      if (k == 3 || k == 5 || k == 12) start = 1'b1;
      else start = 1'b0;
      chk(exp_at(k), "R7 start while busy");
      tick();
    end
    start = 1'b0;

    // R9: start held, back-to-back runs with one done cycle between
    start = 1'b1;
    tick();
    for (int k = 1; k <= TOTAL + 1; k++) begin
      chk(exp_at(k), "R9 first of pair");
      tick();
    end
    chk(V_INNER, "R9 second run begins");
    start = 1'b0;
    for (int k = 2; k <= TOTAL + 1; k++) begin
      tick();
      chk(exp_at(k), "R9 second run");
    end
    tick();
    tick();

    // R10: reset mid-run, then a full-length run
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int k = 1; k < 12; k++) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(V_IDLE, "R10 aborted to idle");
    tick();
    chk(V_IDLE, "R10 stays idle, no done");
    full_run("R10 run after abort");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule